// File: doc/BRIEF.md
# SD read data-block receiver

This block is the host-side receiver for read data arriving on a single-bit SD data line. A pulse marks the last bit of the read command. The block then waits a bounded number of bus ticks for the card's start bit. It deserialises one fixed-size data block, most significant bit first, and streams the bytes out. It also checks the block's 16-bit CRC and its end bit.

In multiple-block mode the receiver re-arms after every block and waits for the next start bit within the same bounded window. This repeats until a pulse reports that a stop command has ended. The stop pulse starts a fixed two-tick tail, after which the receiver is idle. A block that is partly received when the stop arrives never completes. In single-block mode the receiver goes idle on its own after one block.

The data line is sampled only on cycles where the bus clock enable is high. The final byte of each block is held back until the end bit has been sampled. That byte then leaves together with the `last` flag and the block's error flags.

Top module: `sd_rd_block_rx`

## Requirements
- R1: After reset, every output (`byte_valid_o`, `byte_last_o`, `crc_err_o`, `end_err_o`, `timeout_o`) is low, and the receiver ignores the data line until `rd_start_i` is seen.
- R2: `rd_start_i` arms the receiver. `dat_i` is sampled only on cycles with `bus_en_i` high, called ticks. A start bit (`dat_i` = 0) is accepted on any of the first `nac_max_i` ticks after arming. `nac_max_i` must be at least 1.
- R3: If all `nac_max_i` ticks after arming read 1, `timeout_o` pulses high for exactly one cycle and the receiver returns to idle.
- R4: Data bits follow the start bit, most significant bit first. Each completed byte other than the last is presented on `byte_o` with `byte_valid_o` high for one cycle, in the cycle after the tick that carried its bit 0.
- R5: The final byte of a block (byte index BLOCK_BYTES-1) is presented in the cycle after the end-bit tick, with both `byte_valid_o` and `byte_last_o` high.
- R6: A 16-bit CRC follows the data, sent MSB first. It uses polynomial x^16+x^12+x^5+1 (0x1021) with an initial value of zero, computed over the data bits. On a mismatch, `crc_err_o` is high together with `byte_last_o`.
- R7: The tick after the CRC is the end bit. If it reads 0, `end_err_o` is high together with `byte_last_o`.
- R8: In single-block mode (`multi_i` = 0 at the end-bit tick), the receiver returns to idle after the block. Later line activity produces no output.
- R9: In multiple-block mode (`multi_i` = 1 at the end-bit tick), the receiver re-arms its start-bit window immediately and receives further blocks.
- R10: A `stop_end_i` pulse while busy ends reception. No `byte_last_o` is produced for a block in progress. The next two ticks are a tail, then the receiver is idle and ignores the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_start_i | input | 1 | Pulse at the read command's last bit; arms reception |
| multi_i | input | 1 | 1 = multiple-block read, 0 = single block |
| stop_end_i | input | 1 | Pulse at the end bit of the stop command |
| bus_en_i | input | 1 | Bus clock enable; qualifies each data-line sample |
| dat_i | input | 1 | Serial data line from the card |
| nac_max_i | input | NAC_W | Maximum start-bit wait, in ticks |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | `byte_o` valid for this cycle |
| byte_last_o | output | 1 | Marks the final byte of a block |
| crc_err_o | output | 1 | CRC mismatch for the block ending now |
| end_err_o | output | 1 | Missing end bit for the block ending now |
| timeout_o | output | 1 | No start bit within the allowed wait |

## Verification
The bench builds the receiver with BLOCK_BYTES = 4 and NAC_W = 8, so a whole block is 50 ticks. This puts the held-back final byte, back-to-back blocks in multiple-block mode, a stop arriving both between blocks and mid-block, and the post-stop tail within a short run. The maximum wait is set to 5 at run time. This allows testing a start bit on the very last permitted tick and, separately, a timeout one tick later. Bus ticks arrive on every other clock, which shows that idle cycles between ticks neither advance the receiver nor emit output.

// File: rtl/sd_rd_pkg.sv
package sd_rd_pkg;

    // Receiver sequencing states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,   // counting the start-bit window
        ST_DATA = 3'd2,   // data bits of the block
        ST_CRC  = 3'd3,   // sixteen check bits
        ST_END  = 3'd4,   // end bit
        ST_TAIL = 3'd5    // ticks after a stop command
    } rx_state_e;

    localparam int CRC_BITS = 16;

endpackage

// File: rtl/sd_rx_crc16.sv
// One serial step of a 16-bit CRC, MSB-first, no reflection.
module sd_rx_crc16 #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_i,
    input  logic        bit_i,
    output logic [15:0] crc_o
);
    logic feedback;

    always_comb begin
        feedback = crc_i[15] ^ bit_i;
        crc_o    = {crc_i[14:0], 1'b0} ^ (feedback ? POLY : 16'h0000);
    end
endmodule

// File: rtl/sd_rx_bitpos.sv
// Decodes the bit position inside a data block.
module sd_rx_bitpos #(
    parameter int DATA_BITS = 4096,
    parameter int POS_W     = 12
) (
    input  logic [POS_W-1:0] pos_i,
    output logic             byte_end_o,   // this tick carries bit 0 of a byte
    output logic             final_byte_o, // inside the last byte of the block
    output logic             data_end_o    // this tick carries the last data bit
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(DATA_BITS - 1);
    localparam logic [POS_W-1:0] FINAL_POS = POS_W'(DATA_BITS - 8);

    always_comb begin
        byte_end_o   = &pos_i[2:0];
        final_byte_o = (pos_i >= FINAL_POS);
        data_end_o   = (pos_i == LAST_POS);
    end
endmodule

// File: rtl/sd_rd_block_rx.sv
module sd_rd_block_rx
    import sd_rd_pkg::*;
#(
    parameter int          BLOCK_BYTES = 512,
    parameter int          NAC_W       = 16,
    parameter int          TAIL_TICKS  = 2,
    parameter logic [15:0] CRC_POLY    = 16'h1021
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rd_start_i,
    input  logic             multi_i,
    input  logic             stop_end_i,
    input  logic             bus_en_i,
    input  logic             dat_i,
    input  logic [NAC_W-1:0] nac_max_i,
    output logic [7:0]       byte_o,
    output logic             byte_valid_o,
    output logic             byte_last_o,
    output logic             crc_err_o,
    output logic             end_err_o,
    output logic             timeout_o
);
    localparam int DATA_BITS = BLOCK_BYTES * 8;
    localparam int BIT_W     = $clog2(DATA_BITS);
    localparam int POS_W     = (BIT_W < 5) ? 5 : BIT_W;
    localparam logic [POS_W-1:0] CRC_LAST  = POS_W'(CRC_BITS - 1);
    localparam logic [POS_W-1:0] TAIL_LAST = POS_W'(TAIL_TICKS - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [NAC_W-1:0] wait_cnt;
        logic [POS_W-1:0] pos;      // data bit, CRC bit or tail tick index
        logic [15:0]      crc;
        logic [7:0]       shreg;
        logic [7:0]       hold;     // final byte, withheld until the end bit
        logic [7:0]       dout;
        logic             vld;
        logic             lst;
        logic             cerr;
        logic             eerr;
        logic             tmo;
    } rx_regs_t;

    rx_regs_t   q, d;
    logic [15:0] crc_next;
    logic [7:0]  sh_next;
    logic        byte_end, final_byte, data_end;

    sd_rx_crc16 #(.POLY(CRC_POLY)) i_crc (
        .crc_i (q.crc),
        .bit_i (dat_i),
        .crc_o (crc_next)
    );

    sd_rx_bitpos #(.DATA_BITS(DATA_BITS), .POS_W(POS_W)) i_bitpos (
        .pos_i        (q.pos),
        .byte_end_o   (byte_end),
        .final_byte_o (final_byte),
        .data_end_o   (data_end)
    );

    assign sh_next = {q.shreg[6:0], dat_i};

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.lst  = 1'b0;
        d.cerr = 1'b0;
        d.eerr = 1'b0;
        d.tmo  = 1'b0;

        if (stop_end_i && (q.st != ST_IDLE) && (q.st != ST_TAIL)) begin
            // a block in progress is abandoned: its final byte never leaves
            d.st  = ST_TAIL;
            d.pos = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (rd_start_i) begin
                        d.st       = ST_WAIT;
                        d.wait_cnt = '0;
                    end
                end
                ST_WAIT: begin
                    if (bus_en_i) begin
                        if (!dat_i) begin
                            d.st  = ST_DATA;
                            d.pos = '0;
                            d.crc = '0;
                        end else if (q.wait_cnt == nac_max_i - 1'b1) begin
                            d.tmo = 1'b1;
                            d.st  = ST_IDLE;
                        end else begin
                            d.wait_cnt = q.wait_cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (bus_en_i) begin
                        d.shreg = sh_next;
                        d.crc   = crc_next;
                        d.pos   = q.pos + 1'b1;
                        if (byte_end) begin
                            if (final_byte) begin
                                d.hold = sh_next;
                            end else begin
                                d.dout = sh_next;
                                d.vld  = 1'b1;
                            end
                        end
                        if (data_end) begin
                            d.st  = ST_CRC;
                            d.pos = '0;
                        end
                    end
                end
                ST_CRC: begin
                    if (bus_en_i) begin
                        // running the check bits through leaves zero when intact
                        d.crc = crc_next;
                        d.pos = q.pos + 1'b1;
                        if (q.pos == CRC_LAST) d.st = ST_END;
                    end
                end
                ST_END: begin
                    if (bus_en_i) begin
                        d.dout = q.hold;
                        d.vld  = 1'b1;
                        d.lst  = 1'b1;
                        d.cerr = (q.crc != '0);
                        d.eerr = !dat_i;
                        if (multi_i) begin
                            d.st       = ST_WAIT;
                            d.wait_cnt = '0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_TAIL: begin
                    if (bus_en_i) begin
                        if (q.pos == TAIL_LAST) d.st  = ST_IDLE;
                        else                    d.pos = q.pos + 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign byte_o       = q.dout;
    assign byte_valid_o = q.vld;
    assign byte_last_o  = q.lst;
    assign crc_err_o    = q.cerr;
    assign end_err_o    = q.eerr;
    assign timeout_o    = q.tmo;

endmodule

// File: rtl/sd_rd_block_rx_chk.sv
module sd_rd_block_rx_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic bus_en_i,
    input logic stop_end_i,
    input logic byte_valid_o,
    input logic byte_last_o,
    input logic crc_err_o,
    input logic end_err_o,
    input logic timeout_o
);
    AST_VALID_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_valid_o |-> $past(bus_en_i)); // R2

    AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |=> !timeout_o); // R3

    AST_TIMEOUT_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |-> !byte_valid_o); // R3

    AST_LAST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_last_o |-> byte_valid_o); // R5

    AST_CRC_ERR_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crc_err_o |-> byte_last_o); // R6

    AST_END_ERR_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        end_err_o |-> byte_last_o); // R7

    AST_STOP_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_end_i |=> !byte_valid_o); // R10
endmodule

bind sd_rd_block_rx sd_rd_block_rx_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_en_i     (bus_en_i),
    .stop_end_i   (stop_end_i),
    .byte_valid_o (byte_valid_o),
    .byte_last_o  (byte_last_o),
    .crc_err_o    (crc_err_o),
    .end_err_o    (end_err_o),
    .timeout_o    (timeout_o)
);

// File: tb/test_sd_rd_block_rx.sv
`timescale 1ns/1ps
module test_sd_rd_block_rx;
    localparam int BB    = 4;
    localparam int NAC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_start = 1'b0;
    logic             multi = 1'b0;
    logic             stop_end = 1'b0;
    logic             bus_en = 1'b0;
    logic             dat = 1'b1;
    logic [NAC_W-1:0] nac_max = 8'd20;
    logic [7:0]       byte_o;
    logic             byte_valid, byte_last, crc_err, end_err, timeout;

    always #2.5 clk = ~clk; // 200 MHz

    sd_rd_block_rx #(.BLOCK_BYTES(BB), .NAC_W(NAC_W)) i_sd_rd_block_rx (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rd_start_i   (rd_start),
        .multi_i      (multi),
        .stop_end_i   (stop_end),
        .bus_en_i     (bus_en),
        .dat_i        (dat),
        .nac_max_i    (nac_max),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid),
        .byte_last_o  (byte_last),
        .crc_err_o    (crc_err),
        .end_err_o    (end_err),
        .timeout_o    (timeout)
    );

    typedef struct {
        bit       tmo;
        bit [7:0] data;
        bit       last;
        bit       cerr;
        bit       eerr;
        string    req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        if (rst_n && (byte_valid || timeout)) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected output (R8/R10): valid=%0b byte=%02h tmo=%0b, expected none",
                         byte_valid, byte_o, timeout);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.tmo) begin
                    if (!(timeout && !byte_valid)) begin
                        n_fail++;
                        $display("FAIL %s: tmo=%0b valid=%0b, expected tmo=1 valid=0",
                                 e.req, timeout, byte_valid);
                    end
                end else if (!(byte_valid && !timeout && byte_o == e.data && byte_last == e.last
                               && crc_err == e.cerr && end_err == e.eerr)) begin
                    n_fail++;
                    $display("FAIL %s: byte=%02h last=%0b crc=%0b end=%0b tmo=%0b, expected byte=%02h last=%0b crc=%0b end=%0b tmo=0",
                             e.req, byte_o, byte_last, crc_err, end_err, timeout,
                             e.data, e.last, e.cerr, e.eerr);
                end
            end
        end
    end

    // ---------------- driver helpers ----------------
    function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); dat = b; bus_en = 1'b1;
        @(negedge clk); bus_en = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int k = 7; k >= 0; k--) send_bit(v[k]);
    endtask

    task automatic arm(input logic m);
        @(negedge clk); rd_start = 1'b1; multi = m;
        @(negedge clk); rd_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_end = 1'b1;
        @(negedge clk); stop_end = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] v, input bit l, input bit c, input bit e, input string r);
        exp_t x;
        x.tmo = 1'b0; x.data = v; x.last = l; x.cerr = c; x.eerr = e; x.req = r;
        exp_q.push_back(x);
    endtask

    task automatic push_timeout();
        exp_t x;
        x.tmo = 1'b1; x.data = '0; x.last = 1'b0; x.cerr = 1'b0; x.eerr = 1'b0; x.req = "R3";
        exp_q.push_back(x);
    endtask

    // gap high ticks, start bit, BB bytes, CRC, end bit
    task automatic send_block(input int gap, input logic [7:0] seed, input bit bad_crc, input bit bad_end);
        logic [15:0] c;
        logic [7:0]  v;
        c = '0;
        for (int i = 0; i < BB; i++) begin
            v = seed + 8'(i * 37);
            if (i == BB - 1) push_byte(v, 1'b1, bad_crc, bad_end, "R5 R6 R7");
            else             push_byte(v, 1'b0, 1'b0, 1'b0, "R4");
        end
        for (int i = 0; i < gap; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < BB; i++) begin
            v = seed + 8'(i * 37);
            for (int k = 7; k >= 0; k--) begin
                c = crc_step(c, v[k]);
                send_bit(v[k]);
            end
        end
        for (int k = 15; k >= 0; k--) send_bit(c[k] ^ (bad_crc && k == 15));
        send_bit(!bad_end);
    endtask

    task automatic expect_drained(input string r);
        repeat (4) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: %0d expected outputs missing, expected 0", r, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs low after reset
        n_checks++;
        if (byte_valid || byte_last || crc_err || end_err || timeout) begin
            n_fail++;
            $display("FAIL R1: outputs %0b%0b%0b%0b%0b, expected 00000",
                     byte_valid, byte_last, crc_err, end_err, timeout);
        end
        // R1: line activity before arming is ignored
        send_bit(1'b0); send_byte(8'h5A);
        expect_drained("R1");

        // R4 R5 R6: clean single block
        arm(1'b0);
        send_block(2, 8'h11, 1'b0, 1'b0);
        expect_drained("R4");
        // R8: back in idle, a start bit and data produce nothing
        send_bit(1'b0); send_byte(8'hC3); send_byte(8'h3C);
        expect_drained("R8");

        // R6: corrupted CRC bit
        arm(1'b0);
        send_block(1, 8'hA0, 1'b1, 1'b0);
        expect_drained("R6");

        // R7: end bit missing
        arm(1'b0);
        send_block(0, 8'h07, 1'b0, 1'b1);
        expect_drained("R7");

        // R9: two blocks back to back, then stop while waiting (R10)
        arm(1'b1);
        send_block(2, 8'h20, 1'b0, 1'b0);
        send_block(3, 8'h40, 1'b0, 1'b0);
        send_bit(1'b1);
        pulse_stop();
        send_bit(1'b1); send_bit(1'b1);           // tail ticks
        send_bit(1'b0); send_byte(8'hFF);         // ignored after tail
        expect_drained("R9");

        // R10: stop in the middle of the second block
        arm(1'b1);
        send_block(1, 8'h60, 1'b0, 1'b0);
        push_byte(8'h81, 1'b0, 1'b0, 1'b0, "R10");
        push_byte(8'h42, 1'b0, 1'b0, 1'b0, "R10");
        send_bit(1'b1); send_bit(1'b0);
        send_byte(8'h81); send_byte(8'h42);
        pulse_stop();
        send_bit(1'b0); send_bit(1'b0);           // tail ticks
        send_byte(8'h99); send_bit(1'b0); send_byte(8'h00); send_bit(1'b1);
        expect_drained("R10");

        // R3: timeout after nac_max high ticks
        nac_max = 8'd5;
        arm(1'b0);
        push_timeout();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_bit(1'b0); send_byte(8'h77);         // ignored, receiver idle
        expect_drained("R3");

        // R2: start bit on the last permitted tick is accepted
        arm(1'b0);
        send_block(4, 8'h33, 1'b0, 1'b0);
        expect_drained("R2");

        repeat (10) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule